// File: doc/BRIEF.md
# Tagged Address Translation Buffer

This block sits between a processor's load/store port and memory and turns a 16-bit virtual address into a physical one. The address splits into a page number in the high bits and a byte offset in the low bits. The page number and the current process tag are compared at once against every stored mapping. On a match, the stored frame number takes the place of the page number, and the offset passes through unchanged. With the default split of 6 page bits and 10 offset bits, pages are 1024 bytes. For example, address 1502 is page 1, offset 478.

When no entry matches, the block stops taking requests and asks an external page-table walker for the mapping. The walker answers in a single cycle. If the answer says the page is present, the mapping is loaded into the least recently used slot. If the page is absent, a page fault is reported and nothing is loaded. Each entry keeps a write-protect flag and a modified (dirty) flag. A flush input empties the whole buffer. Because every entry carries a process tag, a context switch does not require a flush.

Top module: `tlb_xlate`

## Requirements
- R1: A successful translation returns `resp_pa = {frame, offset}`, where the offset is the low 10 bits of `req_va` copied unchanged and the frame is the 6-bit frame stored for the page `req_va[15:10]`.
- R2: A request accepted while `ready` is high that hits a valid entry gives exactly one outcome pulse (`resp_valid` or `prot_fault`) on the cycle after acceptance, and `walk_req` stays low.
- R3: An entry hits only when both its page number and its process tag equal the request's page number and `cur_pid`. The same page under another tag misses, and the other tag's entry survives.
- R4: On a miss, `walk_req` goes high the cycle after acceptance. It holds steady with the missing page on `walk_vpn` and the request's tag on `walk_pid` until `walk_valid` arrives. `ready` stays low throughout.
- R5: A walker answer with `walk_present` low produces a one-cycle `page_fault` on the next cycle and loads nothing, so repeating the access misses again.
- R6: A walker answer with `walk_present` high loads the mapping and returns the outcome on the cycle after `walk_valid`. A repeat of the access then hits.
- R7: A store (`req_write` = 1) to a page whose protect flag is set yields `prot_fault` and no `resp_valid`. This holds both on a hit and on a refill. Loads from that page translate normally, and `resp_prot` reads 1 for them.
- R8: A store that translates sets the entry's dirty flag. `resp_dirty` is 1 on that response and on every later response for the entry. Loads leave it unchanged, and a refill made for a load starts with it clear.
- R9: While `flush` is high, `ready` is low and no request is taken. After the flush, every earlier mapping misses.
- R10: A refill goes to the lowest-numbered empty slot. When no slot is empty, it goes to the slot whose last hit or fill is oldest.
- R11: After reset, `ready` is 1, and `resp_valid`, `page_fault`, `prot_fault` and `walk_req` are 0. The buffer is empty, so the first access misses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Invalidate every entry |
| cur_pid | input | 4 | Tag of the running process |
| req | input | 1 | Translation request |
| req_write | input | 1 | Request is a store |
| req_va | input | 16 | Virtual address |
| ready | output | 1 | Block can take a request this cycle |
| resp_valid | output | 1 | Translation result pulse |
| resp_pa | output | 16 | Physical address |
| resp_prot | output | 1 | Protect flag of the page |
| resp_dirty | output | 1 | Dirty flag of the page after this access |
| page_fault | output | 1 | Page-not-present pulse |
| prot_fault | output | 1 | Store-to-protected-page pulse |
| walk_req | output | 1 | Refill request, held until answered |
| walk_vpn | output | 6 | Page number to look up |
| walk_pid | output | 4 | Process tag of the lookup |
| walk_valid | input | 1 | One-cycle walker answer |
| walk_present | input | 1 | Page is present in memory |
| walk_protect | input | 1 | Page is write-protected |
| walk_pfn | input | 6 | Frame number of the page |

## Verification
The bench checks the same page under two process tags. A design that ignored the tag would hit where it must miss, or would evict the other process's entry. It checks a not-present answer twice in a row: a design that loaded a mapping on a fault would hit the second time. Stores to a protected page are tried both on refill and on hit, because a design that checked protection on only one path would hand out a writable address. The bench then fills all eight slots, touches the oldest one, and forces an eviction. A FIFO or index-order victim choice would throw out the wrong page. A flush raised together with a request shows whether the request slips through.

// File: rtl/tlb_pkg.sv
// Shared types for the translation buffer.
// Assumes: nothing beyond the standard language.
package tlb_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WALK = 1'b1
    } tlb_state_e;
endpackage

// File: rtl/tlb_entry_array.sv
// Fully associative store of translation entries with parallel tag match.
// Assumes: at most one entry matches a key (fills happen only after a miss
// on that key); fill and dirty update never target the same cycle.
module tlb_entry_array #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 6,
    parameter int PFN_W   = 6,
    parameter int PID_W   = 4,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic [VPN_W-1:0]   lk_vpn,
    input  logic [PID_W-1:0]   lk_pid,
    output logic               lk_hit,
    output logic [IDX_W-1:0]   lk_idx,
    output logic [PFN_W-1:0]   lk_pfn,
    output logic               lk_prot,
    output logic               lk_dirty,
    input  logic               dirty_set,
    input  logic [IDX_W-1:0]   dirty_idx,
    input  logic               fill_en,
    input  logic [IDX_W-1:0]   fill_idx,
    input  logic [VPN_W-1:0]   fill_vpn,
    input  logic [PID_W-1:0]   fill_pid,
    input  logic [PFN_W-1:0]   fill_pfn,
    input  logic               fill_prot,
    input  logic               fill_dirty,
    output logic [ENTRIES-1:0] valid_vec
);
    logic [ENTRIES-1:0] v_q;
    logic [ENTRIES-1:0] prot_q;
    logic [ENTRIES-1:0] dirty_q;
    logic [VPN_W-1:0]   vpn_q [ENTRIES];
    logic [PID_W-1:0]   pid_q [ENTRIES];
    logic [PFN_W-1:0]   pfn_q [ENTRIES];
    logic [ENTRIES-1:0] match;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        // Compare one entry against the key.
        assign match[g] = v_q[g] && (vpn_q[g] == lk_vpn) && (pid_q[g] == lk_pid);

        // Hold one entry: flush, fill or dirty update.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q[g]     <= 1'b0;
                prot_q[g]  <= 1'b0;
                dirty_q[g] <= 1'b0;
                vpn_q[g]   <= '0;
                pid_q[g]   <= '0;
                pfn_q[g]   <= '0;
            end else if (flush) begin
                v_q[g]     <= 1'b0;
            end else if (fill_en && fill_idx == IDX_W'(g)) begin
                v_q[g]     <= 1'b1;
                vpn_q[g]   <= fill_vpn;
                pid_q[g]   <= fill_pid;
                pfn_q[g]   <= fill_pfn;
                prot_q[g]  <= fill_prot;
                dirty_q[g] <= fill_dirty;
            end else if (dirty_set && dirty_idx == IDX_W'(g)) begin
                dirty_q[g] <= 1'b1;
            end
        end
    end

    // Collapse the one-hot match into index and payload.
    always_comb begin
        lk_idx   = '0;
        lk_pfn   = '0;
        lk_prot  = 1'b0;
        lk_dirty = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) begin
                lk_idx   = lk_idx | IDX_W'(i);
                lk_pfn   = lk_pfn | pfn_q[i];
                lk_prot  = lk_prot | prot_q[i];
                lk_dirty = lk_dirty | dirty_q[i];
            end
        end
    end

    assign lk_hit    = |match;
    assign valid_vec = v_q;

    AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));                                   // R3
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (v_q == '0));                             // R9
endmodule

// File: rtl/tlb_lru_age.sv
// Per-entry age counters giving least-recently-used replacement order.
// Assumes: ENTRIES is a power of two; ages always form a permutation of
// 0..ENTRIES-1 (reset seeds them so, and each touch preserves it).
module tlb_lru_age #(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               touch_en,
    input  logic [IDX_W-1:0]   touch_idx,
    input  logic [ENTRIES-1:0] valid_vec,
    output logic [IDX_W-1:0]   victim_idx
);
    localparam logic [IDX_W-1:0] AGE_MAX = IDX_W'(ENTRIES - 1);

    logic [IDX_W-1:0]   age_q [ENTRIES];
    logic [IDX_W-1:0]   touched_age;
    logic [ENTRIES-1:0] oldest;

    assign touched_age = age_q[touch_idx];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_age
        assign oldest[g] = (age_q[g] == AGE_MAX);

        // Age one entry: zero on touch, step up if younger than the touched one.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                age_q[g] <= IDX_W'(g);
            end else if (touch_en) begin
                if (touch_idx == IDX_W'(g))
                    age_q[g] <= '0;
                else if (age_q[g] < touched_age)
                    age_q[g] <= age_q[g] + 1'b1;
            end
        end
    end

    // Pick the lowest empty slot, else the oldest one.
    always_comb begin
        logic found;
        found      = 1'b0;
        victim_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                found      = 1'b1;
                victim_idx = IDX_W'(i);
            end
        end
        if (!found) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (oldest[i]) victim_idx = IDX_W'(i);
            end
        end
    end

    AST_AGE_UNIQUE_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(oldest));                                   // R10
endmodule

// File: rtl/tlb_xlate.sv
// Top of the translation buffer: request handshake, miss walk, fault and
// response generation.
// Assumes: the walker answers with a one-cycle walk_valid pulse at any time
// after walk_req rises; cur_pid is sampled with the request.
module tlb_xlate
    import tlb_pkg::*;
#(
    parameter int VA_W    = 16,
    parameter int VPN_W   = 6,
    parameter int PFN_W   = 6,
    parameter int PID_W   = 4,
    parameter int ENTRIES = 8,
    localparam int OFF_W  = VA_W - VPN_W,
    localparam int PA_W   = PFN_W + OFF_W,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [PID_W-1:0] cur_pid,
    input  logic             req,
    input  logic             req_write,
    input  logic [VA_W-1:0]  req_va,
    output logic             ready,
    output logic             resp_valid,
    output logic [PA_W-1:0]  resp_pa,
    output logic             resp_prot,
    output logic             resp_dirty,
    output logic             page_fault,
    output logic             prot_fault,
    output logic             walk_req,
    output logic [VPN_W-1:0] walk_vpn,
    output logic [PID_W-1:0] walk_pid,
    input  logic             walk_valid,
    input  logic             walk_present,
    input  logic             walk_protect,
    input  logic [PFN_W-1:0] walk_pfn
);
    tlb_state_e         st_q;
    logic [VPN_W-1:0]   cap_vpn;
    logic [PID_W-1:0]   cap_pid;
    logic [OFF_W-1:0]   cap_off;
    logic               cap_wr;

    logic [VPN_W-1:0]   key_vpn;
    logic [PID_W-1:0]   key_pid;
    logic               lk_hit, lk_prot, lk_dirty;
    logic [IDX_W-1:0]   lk_idx, victim_idx, touch_idx;
    logic [PFN_W-1:0]   lk_pfn;
    logic [ENTRIES-1:0] valid_vec;
    logic               accept, hit_go, miss_go, done_walk, fill_go;
    logic               dirty_set, touch_en;

    assign ready     = (st_q == ST_IDLE) && !flush;
    assign accept    = req && ready;
    assign key_vpn   = (st_q == ST_IDLE) ? req_va[VA_W-1:OFF_W] : cap_vpn;
    assign key_pid   = (st_q == ST_IDLE) ? cur_pid : cap_pid;
    assign hit_go    = accept && lk_hit;
    assign miss_go   = accept && !lk_hit;
    assign done_walk = (st_q == ST_WALK) && walk_valid;
    assign fill_go   = done_walk && walk_present && !flush;
    assign dirty_set = hit_go && req_write && !lk_prot && !lk_dirty;
    assign touch_en  = hit_go || fill_go;
    assign touch_idx = hit_go ? lk_idx : victim_idx;

    assign walk_req  = (st_q == ST_WALK);
    assign walk_vpn  = cap_vpn;
    assign walk_pid  = cap_pid;

    tlb_entry_array #(
        .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .PID_W(PID_W)
    ) u_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .lk_vpn     (key_vpn),
        .lk_pid     (key_pid),
        .lk_hit     (lk_hit),
        .lk_idx     (lk_idx),
        .lk_pfn     (lk_pfn),
        .lk_prot    (lk_prot),
        .lk_dirty   (lk_dirty),
        .dirty_set  (dirty_set),
        .dirty_idx  (lk_idx),
        .fill_en    (fill_go),
        .fill_idx   (victim_idx),
        .fill_vpn   (cap_vpn),
        .fill_pid   (cap_pid),
        .fill_pfn   (walk_pfn),
        .fill_prot  (walk_protect),
        .fill_dirty (cap_wr && !walk_protect),
        .valid_vec  (valid_vec)
    );

    tlb_lru_age #(.ENTRIES(ENTRIES)) u_lru (
        .clk        (clk),
        .rst_n      (rst_n),
        .touch_en   (touch_en),
        .touch_idx  (touch_idx),
        .valid_vec  (valid_vec),
        .victim_idx (victim_idx)
    );

    // Sequence between lookup and walk, capturing the missing request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            cap_vpn <= '0;
            cap_pid <= '0;
            cap_off <= '0;
            cap_wr  <= 1'b0;
        end else if (miss_go) begin
            st_q    <= ST_WALK;
            cap_vpn <= req_va[VA_W-1:OFF_W];
            cap_pid <= cur_pid;
            cap_off <= req_va[OFF_W-1:0];
            cap_wr  <= req_write;
        end else if (done_walk) begin
            st_q    <= ST_IDLE;
        end
    end

    // Register the outcome of a hit or a finished walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            page_fault <= 1'b0;
            prot_fault <= 1'b0;
            resp_pa    <= '0;
            resp_prot  <= 1'b0;
            resp_dirty <= 1'b0;
        end else begin
            resp_valid <= 1'b0;
            page_fault <= 1'b0;
            prot_fault <= 1'b0;
            if (hit_go) begin
                if (req_write && lk_prot) prot_fault <= 1'b1;
                else                      resp_valid <= 1'b1;
                resp_pa    <= {lk_pfn, req_va[OFF_W-1:0]};
                resp_prot  <= lk_prot;
                resp_dirty <= lk_dirty || (req_write && !lk_prot);
            end else if (done_walk) begin
                if (!walk_present)                page_fault <= 1'b1;
                else if (cap_wr && walk_protect)  prot_fault <= 1'b1;
                else                              resp_valid <= 1'b1;
                resp_pa    <= {walk_pfn, cap_off};
                resp_prot  <= walk_protect;
                resp_dirty <= cap_wr && !walk_protect;
            end
        end
    end

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({resp_valid, page_fault, prot_fault}));    // R2
    AST_WALK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req && !walk_valid) |=> (walk_req && $stable(walk_vpn) && $stable(walk_pid))); // R4
    AST_BUSY_IN_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req |-> !ready);                               // R4
    AST_PF_FROM_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        page_fault |-> $past(walk_valid && !walk_present)); // R5
    AST_PROT_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        prot_fault |-> resp_prot);                          // R7
    AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && $past(hit_go)) |-> (resp_pa[OFF_W-1:0] == $past(req_va[OFF_W-1:0]))); // R1
endmodule

// File: tb/tb_tlb_xlate.sv
module tb_tlb_xlate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic [3:0]  cur_pid = '0;
    logic        req = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_va = '0;
    logic        ready, resp_valid, resp_prot, resp_dirty, page_fault, prot_fault, walk_req;
    logic [15:0] resp_pa;
    logic [5:0]  walk_vpn;
    logic [3:0]  walk_pid;
    logic        walk_valid = 1'b0;
    logic        walk_present = 1'b0;
    logic        walk_protect = 1'b0;
    logic [5:0]  walk_pfn = '0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    tlb_xlate dut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .cur_pid(cur_pid),
        .req(req), .req_write(req_write), .req_va(req_va), .ready(ready),
        .resp_valid(resp_valid), .resp_pa(resp_pa), .resp_prot(resp_prot),
        .resp_dirty(resp_dirty), .page_fault(page_fault), .prot_fault(prot_fault),
        .walk_req(walk_req), .walk_vpn(walk_vpn), .walk_pid(walk_pid),
        .walk_valid(walk_valid), .walk_present(walk_present),
        .walk_protect(walk_protect), .walk_pfn(walk_pfn)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 50000) begin
            checks = checks + 1;
            errors = errors + 1;
            $display("FAIL watchdog: run hung, act=%0d exp<=50000 cycles", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Page-table model kept by the bench.
    function automatic bit pt_present(input logic [5:0] vpn);
        return (vpn != 6'd13) && (vpn != 6'd40);
    endfunction
    function automatic bit pt_protect(input logic [5:0] vpn);
        return (vpn == 6'd5) || (vpn == 6'd21);
    endfunction
    function automatic logic [5:0] pt_frame(input logic [5:0] vpn, input logic [3:0] pid);
        return vpn ^ {pid, 2'b01};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    logic        o_miss, o_rv, o_pf, o_prf, o_dirty, o_prot;
    logic [15:0] o_pa;

    // One access; services the walk from the model when a miss shows up.
    task automatic access(input logic [3:0] pid, input logic wr, input logic [15:0] va);
        @(negedge clk);
        cur_pid = pid; req = 1'b1; req_write = wr; req_va = va;
        @(negedge clk);
        req = 1'b0;
        o_miss = walk_req;
        if (o_miss) begin
            chk(walk_vpn == va[15:10], "R4 walk page", 32'(walk_vpn), 32'(va[15:10]));
            chk(walk_pid == pid, "R4 walk tag", 32'(walk_pid), 32'(pid));
            chk(ready == 1'b0, "R4 not ready in walk", 32'(ready), 0);
            @(negedge clk);
            chk(walk_req && walk_vpn == va[15:10], "R4 walk held", 32'(walk_req), 1);
            walk_valid = 1'b1;
            walk_present = pt_present(va[15:10]);
            walk_protect = pt_protect(va[15:10]);
            walk_pfn = pt_frame(va[15:10], pid);
            @(negedge clk);
            walk_valid = 1'b0;
        end
        o_rv = resp_valid; o_pf = page_fault; o_prf = prot_fault;
        o_pa = resp_pa; o_dirty = resp_dirty; o_prot = resp_prot;
    endtask

    // Vector: {pid[22:19], write[18], va[17:2], expect_hit[1], expect_dirty[0]}
    localparam logic [22:0] VEC [12] = '{
        {4'd1, 1'b0, 16'd1502,  1'b0, 1'b0},  // first touch of page 1
        {4'd1, 1'b0, 16'd1502,  1'b1, 1'b0},  // hit
        {4'd1, 1'b1, 16'd1029,  1'b1, 1'b1},  // store sets dirty
        {4'd1, 1'b0, 16'd1024,  1'b1, 1'b1},  // dirty persists, offset 0
        {4'd2, 1'b0, 16'd1502,  1'b0, 1'b0},  // other tag misses
        {4'd1, 1'b0, 16'd1100,  1'b1, 1'b1},  // first tag still present
        {4'd1, 1'b1, 16'd5127,  1'b0, 1'b0},  // store to protected, refill
        {4'd1, 1'b0, 16'd5127,  1'b1, 1'b0},  // load protected ok
        {4'd1, 1'b1, 16'd5200,  1'b1, 1'b0},  // store protected, hit
        {4'd1, 1'b0, 16'd13412, 1'b0, 1'b0},  // not present
        {4'd1, 1'b0, 16'd13412, 1'b0, 1'b0},  // still not present
        {4'd1, 1'b1, 16'd3071,  1'b0, 1'b1}   // refill by store, max offset
    };

    initial begin
        repeat (3) @(negedge clk);
        chk(resp_valid == 0 && page_fault == 0 && prot_fault == 0, "R11 outputs in reset",
            {resp_valid, page_fault, prot_fault}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ready == 1'b1, "R11 ready after reset", 32'(ready), 1);
        chk(walk_req == 1'b0, "R11 no walk after reset", 32'(walk_req), 0);

        for (int i = 0; i < 12; i++) begin
            logic [3:0]  pid;
            logic        wr, exp_hit, exp_dirty, e_pf, e_prf, e_rv;
            logic [15:0] va;
            logic [5:0]  vpn;
            {pid, wr, va, exp_hit, exp_dirty} = VEC[i];
            vpn   = va[15:10];
            e_pf  = !exp_hit && !pt_present(vpn);
            e_prf = !e_pf && wr && pt_protect(vpn);
            e_rv  = !e_pf && !e_prf;
            access(pid, wr, va);
            chk(o_miss == !exp_hit, $sformatf("R2 R3 R6 hit/miss vec %0d", i), 32'(!o_miss), 32'(exp_hit));
            chk(o_pf == e_pf, $sformatf("R5 page fault vec %0d", i), 32'(o_pf), 32'(e_pf));
            chk(o_prf == e_prf, $sformatf("R7 prot fault vec %0d", i), 32'(o_prf), 32'(e_prf));
            chk(o_rv == e_rv, $sformatf("R2 R7 resp valid vec %0d", i), 32'(o_rv), 32'(e_rv));
            if (e_rv) begin
                chk(o_pa == {pt_frame(vpn, pid), va[9:0]}, $sformatf("R1 physical addr vec %0d", i),
                    32'(o_pa), 32'({pt_frame(vpn, pid), va[9:0]}));
                chk(o_dirty == exp_dirty, $sformatf("R8 dirty vec %0d", i), 32'(o_dirty), 32'(exp_dirty));
                chk(o_prot == pt_protect(vpn), $sformatf("R7 prot flag vec %0d", i), 32'(o_prot), 32'(pt_protect(vpn)));
            end
        end

        // R9: flush raised with a request blocks it.
        @(negedge clk);
        flush = 1'b1; req = 1'b1; req_write = 1'b0; req_va = 16'd1502; cur_pid = 4'd1;
        #1 chk(ready == 1'b0, "R9 ready low during flush", 32'(ready), 0);
        @(negedge clk);
        flush = 1'b0; req = 1'b0;
        chk(resp_valid == 0 && walk_req == 0, "R9 request not taken in flush",
            {resp_valid, walk_req}, 0);
        access(4'd1, 1'b0, 16'd1502);
        chk(o_miss == 1'b1, "R9 mapping gone after flush", 32'(o_miss), 1);

        // R10: fill all slots, refresh the oldest, force an eviction.
        @(negedge clk); flush = 1'b1; @(negedge clk); flush = 1'b0;
        for (int p = 20; p < 28; p++) access(4'd3, 1'b0, 16'(p * 1024 + 3));
        access(4'd3, 1'b0, 16'(20 * 1024));
        chk(o_miss == 1'b0, "R10 page 20 resident", 32'(o_miss), 0);
        access(4'd3, 1'b0, 16'(28 * 1024));
        chk(o_miss == 1'b1 && o_rv == 1'b1, "R6 refill page 28", 32'(o_miss), 1);
        access(4'd3, 1'b0, 16'(20 * 1024 + 9));
        chk(o_miss == 1'b0, "R10 recently used page kept", 32'(o_miss), 0);
        access(4'd3, 1'b0, 16'(28 * 1024 + 1));
        chk(o_miss == 1'b0, "R6 refilled page hits", 32'(o_miss), 0);
        access(4'd3, 1'b0, 16'(21 * 1024));
        chk(o_miss == 1'b1, "R10 oldest page evicted", 32'(o_miss), 1);
        chk(o_prot == 1'b1 && o_rv == 1'b1, "R7 load of protected page", 32'(o_prot), 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule